// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved outcomes across all branches. That global pattern, joined with the low bits of the branch address, selects one saturating counter out of a single flat array. The counter's top bit is the prediction. With the defaults, two outcome bits select among four counter banks, and each counter is two bits wide.

A lookup is purely combinational. The fetch side presents a PC and gets back a prediction and the history value in force at that moment in the same cycle. It keeps that history with the branch. When the branch resolves, the execute side returns the PC, the saved history and the real outcome. The selected counter moves one step toward the outcome, and the outcome is shifted into the global history.

No address tag is stored, so branches that share index bits share counters. Setting the history length to zero leaves an ordinary per-address table of counters.

Top module: `corr_predictor`

## Requirements
- R1: After reset the global history is zero and every counter holds the weakly-not-taken value (binary 01 for 2-bit counters), so every lookup predicts not taken.
- R2: `lk_taken` is the most significant bit of the counter selected by {current history, `lk_pc[IDX_BITS-1:0]`}, with the history in the upper bits, and it is valid in the same cycle as `lk_pc`.
- R3: A taken resolve increments the selected counter up to the maximum 3 and then holds it there. A not-taken resolve decrements it down to 0 and then holds it there.
- R4: A counter in a strong state needs two consecutive opposite outcomes before its prediction changes.
- R5: Each resolve shifts the history one place toward its MSB and puts the actual outcome in bit 0. With no resolve the history holds. `lk_hist` always shows the current history.
- R6: A resolve updates only the counter selected by {`rs_hist`, `rs_pc[IDX_BITS-1:0]`}. Counters for the same address under other history values do not change.
- R7: No tag is compared. PCs that differ only above bit IDX_BITS-1 read and update the same counter.
- R8: The counter update uses the `rs_hist` supplied with the resolve, not the history register's present value.
- R9: With HIST_BITS=0 the block acts as a plain table of 2-bit counters indexed by `pc[IDX_BITS-1:0]`, and `lk_hist` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | max(HIST_BITS,1) | Current global history, to be kept with the branch |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_hist | input | max(HIST_BITS,1) | History captured when that branch was looked up |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The counter properties assume that when the lookup and the previous cycle's resolve select the same counter, the lookup is reading that counter's freshly written value. This holds only if `rs_*` is stable across the clock edge. The stimulus changes resolve inputs only away from the edge and raises `rs_valid` for exactly one cycle per branch. The properties place no constraint on `rs_hist`, and the stimulus sometimes supplies a stale or arbitrary value on purpose. A second instance built with no history is driven in step with the first and compared against its own per-address model.

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_BITS  = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  localparam int HW       = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [HW-1:0]   lk_hist,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic [HW-1:0]   rs_hist,
  input  logic            rs_taken
);
  localparam int SEL_W   = IDX_BITS + HIST_BITS;
  localparam int ENTRIES = 1 << SEL_W;
  localparam logic [CTR_BITS-1:0] CMAX    = '1;
  localparam logic [CTR_BITS-1:0] WEAK_NT = {1'b0, {(CTR_BITS-1){1'b1}}};

  logic [CTR_BITS-1:0] ctr [ENTRIES];
  logic [HW-1:0]       hist;
  logic [SEL_W-1:0]    lk_sel, rs_sel;
  logic                unused_hi;

  assign unused_hi = ^{lk_pc[PC_W-1:IDX_BITS], rs_pc[PC_W-1:IDX_BITS]};

  generate
    if (HIST_BITS > 0) begin : g_hist
      assign lk_sel = {hist, lk_pc[IDX_BITS-1:0]};
      assign rs_sel = {rs_hist, rs_pc[IDX_BITS-1:0]};
      if (HIST_BITS > 1) begin : g_wide
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)        hist <= '0;
          else if (rs_valid) hist <= {hist[HW-2:0], rs_taken};
      end else begin : g_one
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)        hist <= '0;
          else if (rs_valid) hist <= rs_taken;
      end
    end else begin : g_flat
      logic unused_rs_hist;
      assign unused_rs_hist = ^rs_hist;
      assign lk_sel = lk_pc[IDX_BITS-1:0];
      assign rs_sel = rs_pc[IDX_BITS-1:0];
      assign hist   = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr[i] <= WEAK_NT;
    end else if (rs_valid) begin
      if (rs_taken && ctr[rs_sel] != CMAX)
        ctr[rs_sel] <= ctr[rs_sel] + CTR_BITS'(1);
      else if (!rs_taken && ctr[rs_sel] != '0)
        ctr[rs_sel] <= ctr[rs_sel] - CTR_BITS'(1);
    end
  end

  assign lk_taken = ctr[lk_sel][CTR_BITS-1];
  assign lk_hist  = hist;
endmodule

// File: rtl/corr_predictor_chk.sv
module corr_predictor_chk #(
  parameter int PC_W      = 32,
  parameter int IDX_BITS  = 4,
  parameter int HIST_BITS = 2,
  localparam int HW       = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_taken,
  input logic [HW-1:0]   lk_hist,
  input logic            rs_valid,
  input logic [PC_W-1:0] rs_pc,
  input logic [HW-1:0]   rs_hist,
  input logic            rs_taken
);
  localparam int SEL_W = IDX_BITS + HIST_BITS;
  logic [SEL_W-1:0] lsel, rsel;
  logic unused_c;
  assign unused_c = ^{lk_pc[PC_W-1:IDX_BITS], rs_pc[PC_W-1:IDX_BITS]};

  generate
    if (HIST_BITS > 0) begin : g_h
      assign lsel = {lk_hist, lk_pc[IDX_BITS-1:0]};
      assign rsel = {rs_hist, rs_pc[IDX_BITS-1:0]};

      p_hist_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |=> lk_hist[0] == $past(rs_taken));
      p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> $stable(lk_hist));
      if (HIST_BITS > 1) begin : g_w
        p_hist_age_r5: assert property (@(posedge clk) disable iff (!rst_n)
          rs_valid |=> lk_hist[HW-1:1] == $past(lk_hist[HW-2:0]));
      end
    end else begin : g_f
      logic unused_h;
      assign unused_h = ^rs_hist;
      assign lsel = lk_pc[IDX_BITS-1:0];
      assign rsel = rs_pc[IDX_BITS-1:0];
      p_flat_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hist == '0);
    end
  endgenerate

  p_taken_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rs_valid && rs_taken && lk_taken && lsel == rsel) && lsel == $past(rsel)
      |-> lk_taken);
  p_ntaken_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rs_valid && !rs_taken && !lk_taken && lsel == rsel) && lsel == $past(rsel)
      |-> !lk_taken);
  p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rs_valid) && $stable(lsel) |-> $stable(lk_taken));
endmodule

bind corr_predictor corr_predictor_chk #(
  .PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .lk_hist(lk_hist), .rs_valid(rs_valid), .rs_pc(rs_pc),
  .rs_hist(rs_hist), .rs_taken(rs_taken)
);

// File: tb/test_corr_predictor.sv
`timescale 1ns/1ps
module test_corr_predictor;
  logic        clk = 0, rst_n = 0;
  logic [31:0] lk_pc = '0, rs_pc = '0;
  logic [1:0]  rs_hist = '0, lk_hist;
  logic        rs_valid = 0, rs_taken = 0, lk_taken, f_taken, f_hist;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  corr_predictor i_corr_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_hist(rs_hist), .rs_taken(rs_taken));

  corr_predictor #(.HIST_BITS(0)) i_corr_predictor_flat (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(f_taken),
    .lk_hist(f_hist), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_hist(1'b0), .rs_taken(rs_taken));

  logic [1:0] m_ctr [64];
  logic [1:0] f_ctr [16];
  logic [1:0] m_hist;

  typedef struct { logic t; logic [1:0] h; logic ft; string req; } item_t;
  item_t q[$];

  task automatic resolve(input logic [31:0] pc, input logic [1:0] h, input logic tk);
    @(negedge clk);
    rs_pc = pc; rs_hist = h; rs_taken = tk; rs_valid = 1;
    if (tk && m_ctr[{h, pc[3:0]}] != 2'd3) m_ctr[{h, pc[3:0]}]++;
    else if (!tk && m_ctr[{h, pc[3:0]}] != 2'd0) m_ctr[{h, pc[3:0]}]--;
    if (tk && f_ctr[pc[3:0]] != 2'd3) f_ctr[pc[3:0]]++;
    else if (!tk && f_ctr[pc[3:0]] != 2'd0) f_ctr[pc[3:0]]--;
    m_hist = {m_hist[0], tk};
    @(posedge clk); #1 rs_valid = 0;
  endtask

  task automatic lookup(input logic [31:0] pc, input string req);
    @(negedge clk);
    lk_pc = pc;
    q.push_back('{m_ctr[{m_hist, pc[3:0]}][1], m_hist, f_ctr[pc[3:0]][1], req});
  endtask

  task automatic clear_hist();
    resolve(32'hF, m_hist, 0);
    resolve(32'hF, m_hist, 0);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #2;
      while (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (lk_taken !== it.t) begin
          errors++;
          $display("FAIL %s: pc=%h taken=%b expected %b", it.req, lk_pc, lk_taken, it.t);
        end
        checks++;
        if (lk_hist !== it.h) begin
          errors++;
          $display("FAIL R5: history=%b expected %b", lk_hist, it.h);
        end
        checks++;
        if (f_taken !== it.ft) begin
          errors++;
          $display("FAIL R9: pc=%h flat taken=%b expected %b", lk_pc, f_taken, it.ft);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
    for (int i = 0; i < 16; i++) f_ctr[i] = 2'b01;
    m_hist = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    lookup(32'h0, "R1"); lookup(32'h5, "R1"); lookup(32'hA, "R1");
    // R3 upper saturation, entry (0,5)
    repeat (3) resolve(32'h5, 2'b00, 1);
    clear_hist();
    lookup(32'h5, "R3");
    // R4 strong taken needs two misses
    resolve(32'h5, 2'b00, 0);
    lookup(32'h5, "R4");
    resolve(32'h5, 2'b00, 0);
    lookup(32'h5, "R4");
    repeat (3) resolve(32'h5, 2'b00, 0);
    resolve(32'h5, 2'b00, 1);
    clear_hist();
    lookup(32'h5, "R3");
    // R7 aliasing and R6 isolation
    resolve(32'h7, 2'b00, 1);
    resolve(32'h7, 2'b00, 1);
    clear_hist();
    lookup(32'h7, "R2");
    lookup(32'hABC7, "R7");
    resolve(32'hF, m_hist, 1);
    lookup(32'h7, "R6");
    // R8 update uses supplied history
    clear_hist();
    resolve(32'h9, 2'b10, 1);
    resolve(32'h9, 2'b10, 1);
    resolve(32'hF, m_hist, 1);
    resolve(32'hF, m_hist, 0);
    lookup(32'h9, "R8");
    lookup(32'h19, "R8");
    for (int n = 0; n < 400; n++) begin
      logic [31:0] p;
      logic [1:0] h;
      p = $urandom & 32'hFFFF;
      h = ($urandom % 4 == 0) ? 2'($urandom) : m_hist;
      resolve(p, h, 1'($urandom));
      lookup($urandom & 32'hFFFF, "R2");
    end
    @(negedge clk); #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule